// File: doc/BRIEF.md
# Two-Half Parallel Read Buffer

This block sits between a serial word receiver and a host with a 16-bit parallel bus. It keeps the most recent 32-bit word it was handed. A host then fetches that word as two 16-bit halves by pulsing an active-low read strobe twice. A data-ready flag tells the host that a fresh word is waiting. An internal half pointer decides which half the next strobe returns.

The read strobe is asynchronous to the block clock. It passes through a synchronizer. The bus is enabled for as long as the synchronized strobe is low. The pointer moves on the strobe's rising (end) edge. The bus is modelled as a data vector plus an output enable, and the data vector is forced to zero while the enable is low.

A word that arrives always replaces the stored one, whether or not it has been read. It also sends the pointer back to the low half. A host that was between its two reads therefore gets the low half of the new word on its next strobe.

Top module: `arx_dual_read_buf`

## Requirements
- R1: After reset, data_ready and bus_oe are 0, the stored word is all zeros and the half pointer selects the low half, so a read with no word loaded returns 0x0000.
- R2: A cycle with word_load high stores word_in and sets data_ready from the next cycle on.
- R3: bus_oe is high exactly while the synchronized read strobe is low, which is two clock cycles after rd_n changes. While bus_oe is low, bus_data is 0x0000.
- R4: The first strobe after a load drives word bits 15:0 on bus_data[15:0]. The second strobe drives word bits 31:16 on bus_data[15:0].
- R5: data_ready clears at the end of the first strobe that reads the low half, and stays clear through the second read.
- R6: After the high half has been read, the pointer wraps, so a third strobe returns bits 15:0 again.
- R7: A new load overwrites the stored word even when the previous word was never read, and data_ready stays high.
- R8: A load between the first and second strobes resets the pointer, so the next strobe returns bits 15:0 of the new word.
- R9: When a load lands in the same cycle as the end of a strobe, the load wins: data_ready remains set and the next strobe returns bits 15:0 of the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_in | input | 32 | Word delivered by the receiver |
| word_load | input | 1 | One-cycle strobe that stores word_in |
| rd_n | input | 1 | Active-low host read strobe, asynchronous |
| bus_data | output | 16 | Selected half of the stored word; zero when not driven |
| bus_oe | output | 1 | High while the bus is driven |
| data_ready | output | 1 | High when an unread word is stored |

## Verification
The assertions assume that word_load is synchronous to clk. They also assume that the properties matter only after the internally synchronized reset has been released, since loads arriving earlier are ignored. Neither assumption restricts rd_n, which may change at any time. The stimulus changes all inputs on the falling clock edge. It holds each strobe level for several cycles so that the synchronizer sees clean edges. It places the one coincident load precisely on the cycle in which the strobe end is recognized.

// File: rtl/arx_rd_pkg.sv
package arx_rd_pkg;

  // Events produced by the strobe synchronizer.
  typedef struct packed {
    logic active;  // synchronized strobe is low
    logic done;    // synchronized strobe just returned high
  } strobe_evt_t;

endpackage

// File: rtl/arx_rst_sync.sv
module arx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/arx_strobe_sync.sv
module arx_strobe_sync
  import arx_rd_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strb_n,
  output strobe_evt_t evt
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  always_comb begin
    sync_d[0] = strb_n;
    for (int i = 1; i < STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
    last_d = sync_q[STAGES-1];
  end

  // Idle level of the strobe is high, so reset to all ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    evt.active = ~sync_q[STAGES-1];
    evt.done   = sync_q[STAGES-1] & ~last_q;
  end

endmodule

// File: rtl/arx_word_store.sv
module arx_word_store
  import arx_rd_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BUS_W  = 16,
  localparam int unsigned HALVES = WORD_W / BUS_W,
  localparam int unsigned PTR_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  strobe_evt_t       evt,
  output logic [WORD_W-1:0] store,
  output logic [PTR_W-1:0]  half_sel,
  output logic              ready
);

  localparam logic [PTR_W-1:0] LAST_HALF  = PTR_W'(HALVES - 1);
  localparam logic [PTR_W-1:0] FIRST_HALF = '0;

  logic [WORD_W-1:0] store_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_d;
  logic              rdy_q;
  logic              rdy_d;
  logic              store_en;
  logic              ctl_en;

  always_comb begin
    store_en = load;
    ctl_en   = load | evt.done;
    ptr_d    = ptr_q;
    rdy_d    = rdy_q;
    if (load) begin
      ptr_d = FIRST_HALF;
      rdy_d = 1'b1;
    end else if (evt.done) begin
      if (ptr_q == FIRST_HALF) begin
        rdy_d = 1'b0;
      end
      if (ptr_q == LAST_HALF) begin
        ptr_d = FIRST_HALF;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (store_en) begin
      store_q <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= FIRST_HALF;
      rdy_q <= 1'b0;
    end else if (ctl_en) begin
      ptr_q <= ptr_d;
      rdy_q <= rdy_d;
    end
  end

  assign store    = store_q;
  assign half_sel = ptr_q;
  assign ready    = rdy_q;

endmodule

// File: rtl/arx_half_mux.sv
module arx_half_mux #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BUS_W  = 16,
  localparam int unsigned HALVES = WORD_W / BUS_W,
  localparam int unsigned PTR_W  = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic [WORD_W-1:0] store,
  input  logic [PTR_W-1:0]  half_sel,
  input  logic              drive,
  output logic [BUS_W-1:0]  bus_data,
  output logic              bus_oe
);

  logic [BUS_W-1:0] parts [HALVES];

  for (genvar g = 0; g < HALVES; g++) begin : g_part
    assign parts[g] = store[g*BUS_W +: BUS_W];
  end

  always_comb begin
    bus_oe   = drive;
    bus_data = '0;
    if (drive) begin
      bus_data = parts[half_sel];
    end
  end

endmodule

// File: rtl/arx_dual_read_buf.sv
module arx_dual_read_buf
  import arx_rd_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned BUS_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_load,
  input  logic              rd_n,
  output logic [BUS_W-1:0]  bus_data,
  output logic              bus_oe,
  output logic              data_ready
);

  localparam int unsigned HALVES = WORD_W / BUS_W;
  localparam int unsigned PTR_W  = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic              rst_int_n;
  strobe_evt_t       rd_evt;
  logic [WORD_W-1:0] store;
  logic [PTR_W-1:0]  half_sel;

  arx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  arx_strobe_sync #(.STAGES(SYNC_STAGES)) u_strb (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .strb_n (rd_n),
    .evt    (rd_evt)
  );

  arx_word_store #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (word_load),
    .word     (word_in),
    .evt      (rd_evt),
    .store    (store),
    .half_sel (half_sel),
    .ready    (data_ready)
  );

  arx_half_mux #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_mux (
    .store    (store),
    .half_sel (half_sel),
    .drive    (rd_evt.active),
    .bus_data (bus_data),
    .bus_oe   (bus_oe)
  );

endmodule

// File: rtl/arx_dual_read_buf_chk.sv
module arx_dual_read_buf_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned PTR_W  = 1,
  parameter int unsigned HALVES = 2
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              word_load,
  input logic              read_end,
  input logic [PTR_W-1:0]  half_sel,
  input logic [WORD_W-1:0] store,
  input logic              data_ready,
  input logic              bus_oe,
  input logic [BUS_W-1:0]  bus_data
);

  p_load_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    word_load |=> data_ready);

  p_ready_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(data_ready) |-> $past(word_load));

  p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_oe |-> (bus_data == '0));

  p_ready_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(data_ready) |-> ($past(read_end) && !$past(word_load)));

  p_half_wrap_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (read_end && !word_load && half_sel == PTR_W'(HALVES - 1)) |=> (half_sel == '0));

  p_store_hold_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !word_load |=> $stable(store));

  p_load_first_half_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    word_load |=> (half_sel == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!word_load && !read_end) |=> ($stable(half_sel) && $stable(data_ready)));

endmodule

bind arx_dual_read_buf arx_dual_read_buf_chk #(
  .WORD_W (WORD_W),
  .BUS_W  (BUS_W),
  .PTR_W  (PTR_W),
  .HALVES (HALVES)
) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .word_load  (word_load),
  .read_end   (rd_evt.done),
  .half_sel   (half_sel),
  .store      (store),
  .data_ready (data_ready),
  .bus_oe     (bus_oe),
  .bus_data   (bus_data)
);

// File: tb/arx_dual_read_buf_tb.sv
module arx_dual_read_buf_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] word_in;
  logic        word_load;
  logic        rd_n;
  logic [15:0] bus_data;
  logic        bus_oe;
  logic        data_ready;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  logic [31:0] m_word;
  int          m_ptr;
  logic        m_rdy;
  logic        oe_prev;

  arx_dual_read_buf dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_in    (word_in),
    .word_load  (word_load),
    .rd_n       (rd_n),
    .bus_data   (bus_data),
    .bus_oe     (bus_oe),
    .data_ready (data_ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: one comparison per rising edge of the bus enable.
  always @(negedge clk) begin
    if (bus_oe === 1'b1 && oe_prev !== 1'b1) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R3 unexpected bus drive actual=%h expected=none", bus_data);
      end else begin
        check(tag_q.pop_front(), {16'h0, bus_data}, {16'h0, exp_q.pop_front()});
      end
    end
    oe_prev <= bus_oe;
  end

  task automatic load_word(input logic [31:0] w);
    @(negedge clk);
    word_in   = w;
    word_load = 1'b1;
    @(negedge clk);
    word_load = 1'b0;
    m_word = w;
    m_ptr  = 0;
    m_rdy  = 1'b1;
  endtask

  // Full read strobe; expected half is taken from the bench model.
  task automatic do_read(input string tag);
    @(negedge clk);
    exp_q.push_back(m_ptr == 0 ? m_word[15:0] : m_word[31:16]);
    tag_q.push_back(tag);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    if (m_ptr == 0) m_rdy = 1'b0;
    m_ptr = (m_ptr + 1) % 2;
  endtask

  // Read strobe whose end coincides with a new load (R9).
  task automatic read_with_load(input string tag, input logic [31:0] w);
    @(negedge clk);
    exp_q.push_back(m_ptr == 0 ? m_word[15:0] : m_word[31:16]);
    tag_q.push_back(tag);
    rd_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    word_in   = w;
    word_load = 1'b1;
    @(negedge clk);
    word_load = 1'b0;
    repeat (3) @(negedge clk);
    m_word = w;
    m_ptr  = 0;
    m_rdy  = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    rd_n      = 1'b1;
    word_load = 1'b0;
    word_in   = '0;
    oe_prev   = 1'b0;
    m_word    = '0;
    m_ptr     = 0;
    m_rdy     = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'h0, data_ready}, 32'h0);
    check("R1 oe in reset", {31'h0, bus_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready after reset", {31'h0, data_ready}, 32'h0);
    check("R3 bus quiet when idle", {16'h0, bus_data}, 32'h0);
    do_read("R1 read with no word");
    do_read("R1 second half empty");

    load_word(32'hA5C3_1E7B);
    check("R2 ready after load", {31'h0, data_ready}, 32'h1);
    do_read("R4 low half");
    check("R5 ready cleared by first read", {31'h0, data_ready}, 32'h0);
    do_read("R4 high half");
    check("R5 ready still clear", {31'h0, data_ready}, 32'h0);
    do_read("R6 wrap to low half");
    do_read("R6 high half again");

    load_word(32'h1111_2222);
    load_word(32'h3C3C_F00D);
    check("R7 ready after overwrite", {31'h0, data_ready}, 32'h1);
    do_read("R7 low half of newer word");
    do_read("R7 high half of newer word");

    load_word(32'hDEAD_BEEF);
    do_read("R8 first read old word");
    load_word(32'h0F0F_8421);
    check("R8 ready after mid-pair load", {31'h0, data_ready}, 32'h1);
    do_read("R8 low half of new word");
    do_read("R8 high half of new word");

    load_word(32'h7654_3210);
    do_read("R9 first read");
    read_with_load("R9 high half before coincident load", 32'hCAFE_0123);
    check("R9 ready kept by coincident load", {31'h0, data_ready}, {31'h0, m_rdy});
    do_read("R9 low half after coincident load");
    do_read("R9 high half after coincident load");

    check("R3 bus quiet at end", {16'h0, bus_data}, 32'h0);
    check("R3 scoreboard drained", exp_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule